// File: doc/BRIEF.md
# Interrupt Request and In-Service Tracker

This block keeps the bookkeeping an interrupt controller needs between the arrival of a vectored interrupt and its completion. It holds two 256-entry vector sets. The first set records requests that are waiting. The second records interrupts that are currently being serviced. For each set it keeps a registered copy of the highest vector that is set, and it recomputes that copy on every cycle in which the set changes.

The surrounding controller uses the block as follows. It posts a vector with a request strobe, and it can withdraw a single pending vector with a clear strobe. It moves the top pending vector into service with an accept strobe. Accept is honoured only when the priority class of that vector is above the class of the vector being serviced. An end-of-interrupt strobe retires the top in-service vector. A probe port reads the membership of any one vector in both sets.

Five special interrupt kinds never enter the request set. Each kind has its own pending flag and a latched 8-bit vector. A fixed priority picks which of them is offered next, and a take strobe consumes it. A summary output tells whether any of the non-maskable kinds is pending.

Top module: `intr_track`

## Requirements
- R1: After reset both sets are empty. `irr_top`, `isr_top`, `irr_any`, `isr_any`, `can_accept`, `spc_pend` and `spc_sel_valid` are all 0.
- R2: A vector v is stored in word v[7:5], bit v[4:0]. A request strobe sets v in the pending set. A clear strobe removes v from it. From the cycle after the edge, `probe_irr` and `probe_isr` show whether `probe_vec` is a member of each set.
- R3: From the cycle after any change, `irr_top` is the highest vector in the pending set. The search scans eight 32-bit words from word 7 down to word 0. When the set is empty, `irr_top` is 0 and `irr_any` is 0.
- R4: `isr_top` and `isr_any` follow the in-service set by the same rule as in R3.
- R5: `can_accept` is 1 exactly when the pending set is non-empty and `irr_top[7:4]` is greater than `isr_top[7:4]`. This means pending vectors 0 to 15 can never be accepted.
- R6: `accept` while `can_accept` is 1 removes `irr_top` from the pending set and adds it to the in-service set. `accept` while `can_accept` is 0 has no effect.
- R7: `eoi` removes `isr_top` from the in-service set. When the in-service set is empty, `eoi` has no effect.
- R8: If several operations hit the pending set in one cycle, clear and accept act first and a request for the same vector acts last. The result is that the vector stays pending.
- R9: A special request of kind k sets the pending flag of that kind and latches its vector. The kind encoding is 0 = SMI, 1 = NMI, 2 = INIT, 3 = Startup, 4 = ExtINT. The pending flags appear on `spc_pend[k]`.
- R10: The offered special (`spc_sel_kind`, `spc_sel_vec`) is the pending kind with the lowest code. `spc_take` clears the flag of the offered kind. A request for the same kind in the same cycle wins over the take.
- R11: `spc_unmask` is 1 when any of kinds 0 to 3 is pending. A pending ExtINT on its own does not raise it.
- R12: A special request with a kind code of 5 to 7 changes no flag and no vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Post `req_vec` into the pending set |
| req_vec | input | 8 | Vector to post |
| clr_valid | input | 1 | Withdraw `clr_vec` from the pending set |
| clr_vec | input | 8 | Vector to withdraw |
| accept | input | 1 | Move the top pending vector into service |
| eoi | input | 1 | Retire the top in-service vector |
| probe_vec | input | 8 | Vector whose membership is tested |
| spc_req_valid | input | 1 | Special request strobe |
| spc_req_kind | input | 3 | Special kind code |
| spc_req_vec | input | 8 | Vector latched with the special request |
| spc_take | input | 1 | Consume the offered special |
| irr_top | output | 8 | Highest pending vector, or 0 |
| irr_any | output | 1 | Pending set is non-empty |
| isr_top | output | 8 | Highest in-service vector, or 0 |
| isr_any | output | 1 | In-service set is non-empty |
| can_accept | output | 1 | An accept would be honoured |
| probe_irr | output | 1 | `probe_vec` is pending |
| probe_isr | output | 1 | `probe_vec` is in service |
| spc_pend | output | 5 | Pending flag of each special kind |
| spc_unmask | output | 1 | A non-maskable special is pending |
| spc_sel_valid | output | 1 | A special is offered |
| spc_sel_kind | output | 3 | Kind code of the offered special |
| spc_sel_vec | output | 8 | Latched vector of the offered special |

## Verification
The hardest condition to reach from the ports is a nested in-service stack. To get there, the bench first places a high-class vector in service and then leaves lower-class requests pending. From that state it checks three things: that accept is refused, that an accept attempt is dropped, and that a later end-of-interrupt exposes the vector underneath. It reaches the class-0 corner by clearing every pending vector except a vector below 16, with the in-service set empty. It also drives request, clear and accept at the same vector in one cycle to pin down the ordering rule. A bench-side model recomputes the top vectors with a plain bit-by-bit downward loop rather than a word scan.

// File: rtl/intr_track_pkg.sv
package intr_track_pkg;
  localparam int unsigned VEC_W    = 8;
  localparam int unsigned NUM_VEC  = 1 << VEC_W;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NUM_WORDS = NUM_VEC / WORD_W;
  localparam int unsigned BIT_W    = $clog2(WORD_W);
  localparam int unsigned WIDX_W   = VEC_W - BIT_W;
  localparam int unsigned CLASS_W  = 4;
  localparam int unsigned NUM_SPEC = 5;
  localparam int unsigned KIND_W   = 3;

  typedef enum logic [KIND_W-1:0] {
    SP_SMI   = 3'd0,
    SP_NMI   = 3'd1,
    SP_INIT  = 3'd2,
    SP_START = 3'd3,
    SP_EXT   = 3'd4
  } spec_kind_e;

  // Position of the highest set bit inside one word; 0 for an empty word.
  function automatic logic [BIT_W-1:0] word_msb(input logic [WORD_W-1:0] w);
    logic [BIT_W-1:0] r;
    r = '0;
    for (int b = 0; b < WORD_W; b++) if (w[b]) r = BIT_W'(b);
    return r;
  endfunction

  // Word-wise downward scan: first nonzero word from the top wins.
  function automatic logic [VEC_W-1:0] top_vector(input logic [NUM_VEC-1:0] s);
    logic [VEC_W-1:0] r;
    logic             found;
    r = '0;
    found = 1'b0;
    for (int w = NUM_WORDS - 1; w >= 0; w--) begin
      if (!found && (s[w*WORD_W +: WORD_W] != '0)) begin
        found = 1'b1;
        r = {WIDX_W'(w), word_msb(s[w*WORD_W +: WORD_W])};
      end
    end
    return r;
  endfunction

  function automatic logic [CLASS_W-1:0] prio_class(input logic [VEC_W-1:0] v);
    return v[VEC_W-1 -: CLASS_W];
  endfunction

  function automatic logic [NUM_VEC-1:0] vec_mask(input logic en, input logic [VEC_W-1:0] v);
    logic [NUM_VEC-1:0] m;
    m = '0;
    m[v] = en;
    return m;
  endfunction
endpackage

// File: rtl/intr_vecset.sv
module intr_vecset
  import intr_track_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] set_mask,
  input  logic [NUM_VEC-1:0] clr_mask,
  output logic [NUM_VEC-1:0] bits,
  output logic [VEC_W-1:0]   top,
  output logic               any
);
  logic [NUM_VEC-1:0] bits_nxt;

  // Clears act first, sets last.
  assign bits_nxt = (bits & ~clr_mask) | set_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits <= '0;
      top  <= '0;
      any  <= 1'b0;
    end else begin
      bits <= bits_nxt;
      top  <= top_vector(bits_nxt);
      any  <= |bits_nxt;
    end
  end

  AST_TOP_IS_MEMBER: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> bits[top]);                                          // R3
  AST_EMPTY_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bits == '0) |-> (top == '0 && !any));                        // R3
  AST_NOTHING_ABOVE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (((bits >> top) >> 1) == '0));                        // R4
endmodule

// File: rtl/intr_special.sv
module intr_special
  import intr_track_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [KIND_W-1:0]   req_kind,
  input  logic [VEC_W-1:0]    req_vec,
  input  logic                take,
  output logic [NUM_SPEC-1:0] pend,
  output logic                sel_valid,
  output logic [KIND_W-1:0]   sel_kind,
  output logic [VEC_W-1:0]    sel_vec,
  output logic                unmask
);
  logic [VEC_W-1:0]    vecs [NUM_SPEC];
  logic [NUM_SPEC-1:0] req_hit;
  logic [NUM_SPEC-1:0] take_hit;

  // Lowest kind code has the highest priority.
  always_comb begin
    sel_kind = '0;
    sel_vec  = '0;
    take_hit = '0;
    for (int k = NUM_SPEC - 1; k >= 0; k--) begin
      if (pend[k]) begin
        sel_kind = KIND_W'(k);
        sel_vec  = vecs[k];
        take_hit = '0;
        take_hit[k] = take;
      end
    end
  end

  assign sel_valid = |pend;
  assign unmask = pend[SP_SMI] | pend[SP_NMI] | pend[SP_INIT] | pend[SP_START];

  for (genvar k = 0; k < NUM_SPEC; k++) begin : g_kind
    assign req_hit[k] = req_valid && (req_kind == KIND_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[k] <= 1'b0;
        vecs[k] <= '0;
      end else if (req_hit[k]) begin
        pend[k] <= 1'b1;
        vecs[k] <= req_vec;
      end else if (take_hit[k]) begin
        pend[k] <= 1'b0;
      end
    end
  end

  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sel_valid && !(req_valid && req_kind == sel_kind))
      |=> !pend[$past(sel_kind)]);                                // R10
  AST_REQ_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind < KIND_W'(NUM_SPEC))
      |=> (pend[$past(req_kind)] && vecs[$past(req_kind)] == $past(req_vec))); // R9
  AST_BAD_KIND_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind >= KIND_W'(NUM_SPEC) && !take) |=> $stable(pend)); // R12
endmodule

// File: rtl/intr_track.sv
module intr_track
  import intr_track_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [7:0]          req_vec,
  input  logic                clr_valid,
  input  logic [7:0]          clr_vec,
  input  logic                accept,
  input  logic                eoi,
  input  logic [7:0]          probe_vec,
  input  logic                spc_req_valid,
  input  logic [2:0]          spc_req_kind,
  input  logic [7:0]          spc_req_vec,
  input  logic                spc_take,
  output logic [7:0]          irr_top,
  output logic                irr_any,
  output logic [7:0]          isr_top,
  output logic                isr_any,
  output logic                can_accept,
  output logic                probe_irr,
  output logic                probe_isr,
  output logic [4:0]          spc_pend,
  output logic                spc_unmask,
  output logic                spc_sel_valid,
  output logic [2:0]          spc_sel_kind,
  output logic [7:0]          spc_sel_vec
);
  logic [NUM_VEC-1:0] irr_bits, isr_bits;
  logic [NUM_VEC-1:0] irr_set, irr_clr, isr_set, isr_clr;
  logic               acc_fire;
  logic               eoi_fire;

  assign can_accept = irr_any && (prio_class(irr_top) > prio_class(isr_top));
  assign acc_fire   = accept && can_accept;
  assign eoi_fire   = eoi && isr_any;

  assign irr_set = vec_mask(req_valid, req_vec);
  assign irr_clr = vec_mask(clr_valid, clr_vec) | vec_mask(acc_fire, irr_top);
  assign isr_set = vec_mask(acc_fire, irr_top);
  assign isr_clr = vec_mask(eoi_fire, isr_top);

  intr_vecset u_irr (
    .clk(clk), .rst_n(rst_n), .set_mask(irr_set), .clr_mask(irr_clr),
    .bits(irr_bits), .top(irr_top), .any(irr_any)
  );

  intr_vecset u_isr (
    .clk(clk), .rst_n(rst_n), .set_mask(isr_set), .clr_mask(isr_clr),
    .bits(isr_bits), .top(isr_top), .any(isr_any)
  );

  assign probe_irr = irr_bits[probe_vec];
  assign probe_isr = isr_bits[probe_vec];

  intr_special u_spc (
    .clk(clk), .rst_n(rst_n),
    .req_valid(spc_req_valid), .req_kind(spc_req_kind), .req_vec(spc_req_vec),
    .take(spc_take), .pend(spc_pend), .sel_valid(spc_sel_valid),
    .sel_kind(spc_sel_kind), .sel_vec(spc_sel_vec), .unmask(spc_unmask)
  );

  AST_ACCEPT_ENTERS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> isr_bits[$past(irr_top)]);                       // R6
  AST_ACCEPT_LEAVES_IRR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !(req_valid && req_vec == irr_top)) |=> !irr_bits[$past(irr_top)]); // R6
  AST_EOI_EMPTY_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !isr_any && !acc_fire) |=> $stable(isr_bits));        // R7
  AST_REFUSED_ACCEPT_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !can_accept && !eoi) |=> $stable(isr_bits));       // R5
endmodule

// File: tb/test_intr_track.sv
module test_intr_track;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, clr_valid = 0, accept = 0, eoi = 0, spc_req_valid = 0, spc_take = 0;
  logic [7:0] req_vec = 0, clr_vec = 0, probe_vec = 0, spc_req_vec = 0;
  logic [2:0] spc_req_kind = 0;
  logic [7:0] irr_top, isr_top, spc_sel_vec;
  logic irr_any, isr_any, can_accept, probe_irr, probe_isr, spc_unmask, spc_sel_valid;
  logic [4:0] spc_pend;
  logic [2:0] spc_sel_kind;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [255:0] m_irr = '0, m_isr = '0;

  always #10 clk = ~clk;

  intr_track i_intr_track (.*);

  function automatic int m_top(input logic [255:0] s);
    for (int v = 255; v >= 0; v--) if (s[v]) return v;
    return 0;
  endfunction

  function automatic bit m_can();
    return (m_irr != 0) && ((m_top(m_irr) / 16) > (m_top(m_isr) / 16));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock with the inputs already driven; model updated by requirement rules.
  task automatic step();
    int t, ti;
    bit can;
    t = m_top(m_irr); ti = m_top(m_isr); can = m_can();
    if (clr_valid) m_irr[clr_vec] = 1'b0;
    if (accept && can) begin m_irr[t] = 1'b0; m_isr[t] = 1'b1; end
    if (req_valid) m_irr[req_vec] = 1'b1;
    if (eoi && m_isr != 0) m_isr[ti] = 1'b0;
    if (accept && can) m_isr[t] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; clr_valid = 0; accept = 0; eoi = 0; spc_req_valid = 0; spc_take = 0;
  endtask

  task automatic cmp_model(input string req);
    chk({req, " irr_top"}, irr_top, m_top(m_irr));
    chk({req, " irr_any"}, irr_any, m_irr != 0);
    chk({req, " isr_top"}, isr_top, m_top(m_isr));
    chk({req, " isr_any"}, isr_any, m_isr != 0);
    chk({req, " can_accept"}, can_accept, m_can());
  endtask

  task automatic post(input int v);
    req_valid = 1; req_vec = 8'(v); step();
  endtask

  task automatic t_reset();
    chk("R1 irr_top", irr_top, 0);
    chk("R1 isr_top", isr_top, 0);
    chk("R1 any", {irr_any, isr_any, can_accept}, 0);
    chk("R1 spc", {spc_pend, spc_sel_valid}, 0);
  endtask

  task automatic t_scan();
    post(0);
    chk("R3 vec0 any", irr_any, 1);
    chk("R3 vec0 top", irr_top, 0);
    post(37); chk("R3 top37", irr_top, 37);
    post(5);  chk("R3 top stays 37", irr_top, 37);
    post(200); chk("R3 top200", irr_top, 200);
    post(63); cmp_model("R3");
    probe_vec = 37; #1; chk("R2 probe 37", probe_irr, 1);
    probe_vec = 36; #1; chk("R2 probe 36", probe_irr, 0);
    clr_valid = 1; clr_vec = 0; step();
    probe_vec = 0; #1; chk("R2 clear vec0", probe_irr, 0);
    cmp_model("R2");
  endtask

  task automatic t_accept();
    chk("R5 can_accept", can_accept, 1);
    accept = 1; step();
    chk("R6 isr_top 200", isr_top, 200);
    chk("R6 irr_top 63", irr_top, 63);
    probe_vec = 200; #1; chk("R6 moved", {probe_irr, probe_isr}, 2'b01);
    chk("R5 blocked by class", can_accept, 0);
    accept = 1; step();
    chk("R6 refused accept nop", isr_top, 200);
    cmp_model("R6");
    accept = 1; eoi = 1; step();                  // refused accept, eoi retires 200
    cmp_model("R7 eoi");
    accept = 1; step(); chk("R6 accept 63", isr_top, 63);
    post(50);                                     // class 3 equal to 63's class
    chk("R5 equal class", can_accept, 0);
    post(130); accept = 1; step();
    chk("R4 nested top", isr_top, 130);
    eoi = 1; step(); chk("R7 exposes 63", isr_top, 63);
    eoi = 1; step(); chk("R7 empty", isr_any, 0);
    eoi = 1; step(); chk("R7 eoi empty nop", isr_any, 0);
    chk("R7 irr untouched", irr_top, 50);
    cmp_model("R7");
  endtask

  task automatic t_class0();
    clr_valid = 1; clr_vec = 50; step();
    clr_valid = 1; clr_vec = 37; step();
    chk("R5 only vec5 left", irr_top, 5);
    chk("R5 class0 refused", can_accept, 0);
    accept = 1; step();
    chk("R5 class0 accept nop", isr_any, 0);
    cmp_model("R5");
  endtask

  task automatic t_order();
    clr_valid = 1; clr_vec = 90; req_valid = 1; req_vec = 90; step();
    probe_vec = 90; #1; chk("R8 req beats clear", probe_irr, 1);
    accept = 1; req_valid = 1; req_vec = 90; step();
    chk("R8 req beats accept", {probe_irr, probe_isr}, 2'b11);
    cmp_model("R8");
  endtask

  task automatic t_special();
    spc_req_valid = 1; spc_req_kind = 2; spc_req_vec = 8'h11; step();
    spc_req_valid = 1; spc_req_kind = 4; spc_req_vec = 8'h22; step();
    chk("R9 pend", spc_pend, 5'b10100);
    chk("R11 init unmask", spc_unmask, 1);
    chk("R10 sel init", {spc_sel_kind, spc_sel_vec}, {3'd2, 8'h11});
    spc_take = 1; step();
    chk("R10 take init", spc_pend, 5'b10000);
    chk("R11 extint only", spc_unmask, 0);
    chk("R10 sel ext", {spc_sel_valid, spc_sel_kind, spc_sel_vec}, {1'b1, 3'd4, 8'h22});
    spc_req_valid = 1; spc_req_kind = 1; spc_req_vec = 8'h33; step();
    spc_req_valid = 1; spc_req_kind = 0; spc_req_vec = 8'h44; step();
    chk("R10 sel smi", {spc_sel_kind, spc_sel_vec}, {3'd0, 8'h44});
    spc_req_valid = 1; spc_req_kind = 6; spc_req_vec = 8'h55; step();
    chk("R12 bad kind", {spc_pend, spc_sel_vec}, {5'b10011, 8'h44});
    spc_take = 1; spc_req_valid = 1; spc_req_kind = 0; spc_req_vec = 8'h66; step();
    chk("R10 req beats take", {spc_sel_kind, spc_sel_vec}, {3'd0, 8'h66});
    spc_take = 1; step();
    chk("R10 sel nmi", {spc_sel_kind, spc_sel_vec}, {3'd1, 8'h33});
    spc_req_valid = 1; spc_req_kind = 3; spc_req_vec = 8'h77; step();
    spc_take = 1; step();
    chk("R9 start latched", {spc_pend, spc_sel_kind, spc_sel_vec}, {5'b11000, 3'd3, 8'h77});
    spc_take = 1; step(); spc_take = 1; step();
    chk("R10 all taken", {spc_pend, spc_sel_valid, spc_unmask}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_scan();
    t_accept();
    t_class0();
    t_order();
    t_special();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule